// File: doc/BRIEF.md
# Host Port Slave Bridge

The bridge lets an external host read and write a 32-bit internal memory through a narrow 16-bit parallel port. The host picks one of four targets with a 2-bit select: a control register, an address register, or the data path in one of two modes. Every 32-bit quantity crosses the port as two halfword transfers. A halfword-select line marks the first and second transfer. A bit in the control register decides whether the low or the high half moves first.

Data writes are collected in a latch and become one memory write when the second half arrives. Data reads fetch a full word on the first half and return the second half from that latch. In the post-increment mode the address advances by one word when the second transfer ends. On reads the next word is then fetched at once, so the following first half needs no new memory access.

The host holds its strobe high for each transfer. The bridge acts on the rising edge of the strobe. A busy output tells the host when to wait before it samples read data or releases the strobe. The memory side is a request/acknowledge interface. A request stays raised until it is acknowledged.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the order bit is 0 (high half first), the address register is 0, and `host_busy`, `mem_req` and `host_doe` are low.
- R2: `host_sel` selects the target: 2'b00 control, 2'b01 address, 2'b10 data with post-increment, 2'b11 data with fixed address.
- R3: With order bit 1, the transfer with `host_half`=0 carries bits 15:0 and the transfer with `host_half`=1 carries bits 31:16. With order bit 0 the two halves are swapped. This holds for both reads and writes.
- R4: A control write on either half loads the order bit from `host_din[0]`. A control read returns the order bit at bits 0 and 16 of the word and zeros elsewhere.
- R5: A data write with `host_half`=0 only updates the latch and starts no memory access. A data write with `host_half`=1 starts exactly one memory write. That write uses the address register and the assembled 32-bit word.
- R6: `host_busy` goes high on the clock edge that accepts a strobe needing memory, and goes low on the edge after `mem_ack`. `mem_req`, `mem_we` and `mem_addr` hold steady until acknowledged.
- R7: A data read with `host_half`=0 starts a memory read from the address register and returns the first half of the fetched word. The read with `host_half`=1 returns the other half from the latch and starts no access.
- R8: In post-increment mode, dropping the strobe after a `host_half`=1 data transfer adds 4 to the address. After a read it also starts a prefetch read of the new address. The next `host_half`=0 read then returns that word with no further memory access.
- R9: In fixed mode the address never changes, and every `host_half`=0 read fetches from memory again.
- R10: A strobe rising edge that arrives while `host_busy` is high is ignored.
- R11: `host_doe` is high only while `host_stb` is high, `host_rnw`=1 and `host_busy` is low.
- R12: With order bit 1, writing 16'h0000 then 16'h8000 to the address register sets it to 32'h8000_0000. A following data read is then issued at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sel | input | 2 | Target select (R2 encoding) |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_half | input | 1 | 0 = first halfword, 1 = second halfword |
| host_stb | input | 1 | Transfer strobe, held high for the transfer |
| host_din | input | 16 | Halfword written by the host |
| host_dout | output | 16 | Halfword returned to the host |
| host_doe | output | 1 | Output enable for host_dout |
| host_busy | output | 1 | Not-ready: host must wait |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The assertions check the request handshake on every cycle. They check that a request holds still until acknowledged, that no new access starts while one is open, and that memory writes come only from second-half strobes. They also check that the address moves by one word only when an increment-mode transfer closes, and stays fixed in fixed mode. Only the bench scenarios can show the results as seen from the port. These are the halfword order under both settings of the control bit, the value that reaches memory, and whether a prefetch saves a fetch. They also cover whether a strobe during busy really changes nothing.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_ADDR     = 2'b01,
    SEL_DATA_INC = 2'b10,
    SEL_DATA_FIX = 2'b11
  } hsel_e;

  // A transfer carries the low half when the order bit and the
  // second-transfer flag differ.
  function automatic logic low_half(input logic lo_first, input logic second);
    return lo_first ^ second;
  endfunction

endpackage

// File: rtl/hpb_rst_sync.sv
module hpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hpb_stb_edge.sv
module hpb_stb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign rise = stb & ~stb_q;
  assign fall = ~stb & stb_q;
endmodule

// File: rtl/hpb_mem_port.sv
module hpb_mem_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  logic              req_q, req_n;
  logic              we_q, we_n;
  logic [DATA_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;

  always_comb begin
    req_n   = req_q;
    we_n    = we_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    if (req_q && mem_ack) begin
      req_n = 1'b0;
    end else if (!req_q && start) begin
      req_n   = 1'b1;
      we_n    = start_we;
      addr_n  = start_addr;
      wdata_n = start_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q   <= req_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = req_q;
  assign rd_done   = req_q & mem_ack & ~we_q;
  assign rd_data   = mem_rdata;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !mem_ack) |=> (req_q && $stable(addr_q) && $stable(we_q)));

  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && mem_ack) |=> !req_q);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req_q);
endmodule

// File: rtl/hpb_ctl.sv
module hpb_ctl
  import hpb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  input  logic                fall,
  input  logic                busy,
  input  hsel_e               sel,
  input  logic                rnw,
  input  logic                half,
  input  logic [DATA_W/2-1:0] din,
  input  logic                rd_done,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                lo_first,
  output logic [DATA_W-1:0]   addr,
  output logic [DATA_W-1:0]   latch,
  output logic                start,
  output logic                start_we,
  output logic [DATA_W-1:0]   start_addr,
  output logic [DATA_W-1:0]   start_wdata
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(DATA_W / 8);

  logic              lf_q, lf_n;
  logic [DATA_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] lat_q, lat_n;
  logic              pf_q, pf_n;     // latch holds prefetched word at addr_q
  logic              h1_q, h1_n;     // last accepted: increment-mode second half
  logic              h1rd_q, h1rd_n; // ... and it was a read
  logic              acc, lowp;

  assign acc  = rise & ~busy;
  assign lowp = low_half(lf_q, half);

  always_comb begin
    lf_n        = lf_q;
    addr_n      = addr_q;
    lat_n       = lat_q;
    pf_n        = pf_q;
    h1_n        = h1_q;
    h1rd_n      = h1rd_q;
    start       = 1'b0;
    start_we    = 1'b0;
    start_addr  = addr_q;
    start_wdata = lat_q;

    if (rd_done) lat_n = rd_data;

    if (acc) begin
      h1_n   = (sel == SEL_DATA_INC) && half;
      h1rd_n = rnw;
      if (!rnw) pf_n = 1'b0;
      unique case (sel)
        SEL_CTRL: begin
          if (!rnw) lf_n = din[0];
        end
        SEL_ADDR: begin
          if (!rnw) begin
            if (lowp) addr_n[HALF_W-1:0]      = din;
            else      addr_n[DATA_W-1:HALF_W] = din;
          end
        end
        default: begin
          if (!rnw) begin
            if (lowp) lat_n[HALF_W-1:0]      = din;
            else      lat_n[DATA_W-1:HALF_W] = din;
            if (half) begin
              start       = 1'b1;
              start_we    = 1'b1;
              start_wdata = lat_n;
            end
          end else if (!half) begin
            if (!((sel == SEL_DATA_INC) && pf_q)) start = 1'b1;
            if (sel == SEL_DATA_FIX) pf_n = 1'b0;
          end
        end
      endcase
    end else if (fall && h1_q && !busy) begin
      h1_n   = 1'b0;
      addr_n = addr_q + STEP_V;
      if (h1rd_q) begin
        start      = 1'b1;
        start_addr = addr_n;
        pf_n       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q   <= 1'b0;
      addr_q <= '0;
      lat_q  <= '0;
      pf_q   <= 1'b0;
      h1_q   <= 1'b0;
      h1rd_q <= 1'b0;
    end else begin
      lf_q   <= lf_n;
      addr_q <= addr_n;
      lat_q  <= lat_n;
      pf_q   <= pf_n;
      h1_q   <= h1_n;
      h1rd_q <= h1rd_n;
    end
  end

  assign lo_first = lf_q;
  assign addr     = addr_q;
  assign latch    = lat_q;

  // R5
  wr_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_we) |-> (rise && half && !rnw));

  // R7
  rd_second_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && rnw && half) |-> !start);

  // R8
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && h1_q && !busy) |=> (addr_q == $past(addr_q) + STEP_V));

  // R9
  fix_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (sel == SEL_DATA_FIX)) |=> $stable(addr_q));
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hpb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_sel,
  input  logic                host_rnw,
  input  logic                host_half,
  input  logic                host_stb,
  input  logic [DATA_W/2-1:0] host_din,
  output logic [DATA_W/2-1:0] host_dout,
  output logic                host_doe,
  output logic                host_busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  localparam int HALF_W = DATA_W / 2;

  logic              rst_i_n;
  logic              rise, fall, busy;
  hsel_e             sel;
  logic              lf;
  logic [DATA_W-1:0] addr, latch;
  logic              start, start_we;
  logic [DATA_W-1:0] start_addr, start_wdata;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] rd_word;

  assign sel = hsel_e'(host_sel);

  hpb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  hpb_stb_edge u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .stb   (host_stb),
    .rise  (rise),
    .fall  (fall)
  );

  hpb_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .rise        (rise),
    .fall        (fall),
    .busy        (busy),
    .sel         (sel),
    .rnw         (host_rnw),
    .half        (host_half),
    .din         (host_din),
    .rd_done     (rd_done),
    .rd_data     (rd_data),
    .lo_first    (lf),
    .addr        (addr),
    .latch       (latch),
    .start       (start),
    .start_we    (start_we),
    .start_addr  (start_addr),
    .start_wdata (start_wdata)
  );

  hpb_mem_port #(.DATA_W(DATA_W)) u_mem (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .start       (start),
    .start_we    (start_we),
    .start_addr  (start_addr),
    .start_wdata (start_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .busy        (busy),
    .rd_done     (rd_done),
    .rd_data     (rd_data)
  );

  // Read word selection; the order bit is mirrored into both halves.
  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_word = {{(HALF_W-1){1'b0}}, lf, {(HALF_W-1){1'b0}}, lf};
      SEL_ADDR: rd_word = addr;
      default:  rd_word = latch;
    endcase
  end

  assign host_dout = low_half(lf, host_half) ? rd_word[HALF_W-1:0]
                                             : rd_word[DATA_W-1:HALF_W];
  assign host_doe  = host_stb & host_rnw & ~busy;
  assign host_busy = busy;

  // R11
  doe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!host_stb || !host_rnw) |-> !host_doe);
endmodule

// File: tb/test_hostport_bridge.sv
module test_hostport_bridge;
  logic        clk;
  logic        rst_n;
  logic [1:0]  host_sel;
  logic        host_rnw, host_half, host_stb;
  logic [15:0] host_din, host_dout;
  logic        host_doe, host_busy;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  int req_cnt = 0;
  logic        last_we;
  logic [31:0] last_addr, last_wdata;
  logic [31:0] mem [16];
  int lat_cnt;
  localparam int LAT = 4;

  hostport_bridge i_hostport_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rnw(host_rnw),
    .host_half(host_half), .host_stb(host_stb), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .host_busy(host_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model: acknowledges after LAT cycles, drives at negedge.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = {16'hA000 + 16'(i), 16'h0B00 + 16'(i)};
      mem_ack = 1'b0; mem_rdata = '0; lat_cnt = 0;
    end else begin
      mem_ack = 1'b0;
      if (mem_req) begin
        lat_cnt++;
        if (lat_cnt == LAT) begin
          lat_cnt = 0;
          mem_ack = 1'b1;
          req_cnt++;
          last_we = mem_we; last_addr = mem_addr; last_wdata = mem_wdata;
          if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[5:2]];
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (host_busy) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] s, input logic r, input logic h,
                      input logic [15:0] d, output logic [15:0] q, output logic sb);
    sb = 1'b0;
    while (host_busy) @(negedge clk);
    host_sel = s; host_rnw = r; host_half = h; host_din = d; host_stb = 1'b1;
    @(negedge clk);
    while (host_busy) begin sb = 1'b1; @(negedge clk); end
    q = host_dout;
    host_stb = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        chk;
    logic [1:0]  sel;
    logic        rnw;
    logic        half;
    logic [15:0] din;
    logic [15:0] exp;
  } vec_t;

  // Encodings per R2: 00 control, 01 address, 10 data+inc, 11 data fixed.
  localparam vec_t VECS [18] = '{
    '{1'b0, 2'b00, 1'b0, 1'b0, 16'h0001, 16'h0000}, // R4 order bit := 1
    '{1'b0, 2'b00, 1'b0, 1'b1, 16'h0001, 16'h0000},
    '{1'b1, 2'b00, 1'b1, 1'b0, 16'h0000, 16'h0001}, // R4 bit 0
    '{1'b1, 2'b00, 1'b1, 1'b1, 16'h0000, 16'h0001}, // R4 bit 16 mirror
    '{1'b0, 2'b01, 1'b0, 1'b0, 16'h0010, 16'h0000}, // R3 low half first
    '{1'b0, 2'b01, 1'b0, 1'b1, 16'h0000, 16'h0000},
    '{1'b1, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0010}, // R3
    '{1'b1, 2'b01, 1'b1, 1'b1, 16'h0000, 16'h0000}, // R3
    '{1'b0, 2'b11, 1'b0, 1'b0, 16'h5678, 16'h0000}, // R5
    '{1'b0, 2'b11, 1'b0, 1'b1, 16'h1234, 16'h0000}, // R5
    '{1'b1, 2'b11, 1'b1, 1'b0, 16'h0000, 16'h5678}, // R7
    '{1'b1, 2'b11, 1'b1, 1'b1, 16'h0000, 16'h1234}, // R7
    '{1'b0, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R3 order bit := 0
    '{1'b0, 2'b00, 1'b0, 1'b1, 16'h0000, 16'h0000},
    '{1'b1, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R3 high half first
    '{1'b1, 2'b01, 1'b1, 1'b1, 16'h0000, 16'h0010}, // R3
    '{1'b1, 2'b11, 1'b1, 1'b0, 16'h0000, 16'h1234}, // R3 R9 refetch
    '{1'b1, 2'b11, 1'b1, 1'b1, 16'h0000, 16'h5678}  // R3
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic sb;
    int c0;
    host_sel = 2'b00; host_rnw = 1'b0; host_half = 1'b0; host_stb = 1'b0; host_din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'd0, host_busy}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 doe", {31'd0, host_doe}, 32'd0);
    xfer(2'b00, 1'b1, 1'b0, 16'h0, q, sb);
    check("R1 ctrl", {16'd0, q}, 32'd0);
    xfer(2'b01, 1'b1, 1'b1, 16'h0, q, sb);
    check("R1 addr", {16'd0, q}, 32'd0);

    // Vector table
    for (int i = 0; i < 18; i++) begin
      xfer(VECS[i].sel, VECS[i].rnw, VECS[i].half, VECS[i].din, q, sb);
      if (VECS[i].chk) check($sformatf("R2 R3 vec%0d", i), {16'd0, q}, {16'd0, VECS[i].exp});
    end
    check("R5 mem word", mem[4], 32'h1234_5678);

    // R12 address 0x8000_0000 with low half first
    xfer(2'b00, 1'b0, 1'b0, 16'h0001, q, sb);
    xfer(2'b01, 1'b0, 1'b0, 16'h0000, q, sb);
    xfer(2'b01, 1'b0, 1'b1, 16'h8000, q, sb);
    xfer(2'b01, 1'b1, 1'b1, 16'h0000, q, sb);
    check("R12 addr high", {16'd0, q}, 32'h8000);
    xfer(2'b11, 1'b1, 1'b0, 16'h0000, q, sb);
    check("R12 mem_addr", last_addr, 32'h8000_0000);
    check("R7 read low", {16'd0, q}, {16'd0, mem[0][15:0]});

    // R5 write assembly and request count; R6 busy
    c0 = req_cnt;
    xfer(2'b11, 1'b0, 1'b0, 16'hAAAA, q, sb);
    wait_idle();
    check("R5 no req on first half", req_cnt, c0);
    check("R6 no busy on first half", {31'd0, sb}, 32'd0);
    xfer(2'b11, 1'b0, 1'b1, 16'h5555, q, sb);
    check("R6 busy on second half", {31'd0, sb}, 32'd1);
    check("R5 one write", req_cnt, c0 + 1);
    check("R5 write flag", {31'd0, last_we}, 32'd1);
    check("R5 write data", last_wdata, 32'h5555_AAAA);
    check("R5 write addr", last_addr, 32'h8000_0000);

    // R8 post-increment with prefetch
    xfer(2'b01, 1'b0, 1'b0, 16'h0020, q, sb);
    xfer(2'b01, 1'b0, 1'b1, 16'h0000, q, sb);
    c0 = req_cnt;
    xfer(2'b10, 1'b1, 1'b0, 16'h0, q, sb);
    check("R8 word0 low", {16'd0, q}, {16'd0, mem[8][15:0]});
    xfer(2'b10, 1'b1, 1'b1, 16'h0, q, sb);
    check("R8 word0 high", {16'd0, q}, {16'd0, mem[8][31:16]});
    wait_idle();
    check("R8 prefetch issued", req_cnt, c0 + 2);
    check("R8 prefetch addr", last_addr, 32'h0000_0024);
    xfer(2'b10, 1'b1, 1'b0, 16'h0, q, sb);
    check("R8 word1 low", {16'd0, q}, {16'd0, mem[9][15:0]});
    check("R8 no refetch", req_cnt, c0 + 2);
    xfer(2'b10, 1'b1, 1'b1, 16'h0, q, sb);
    check("R8 word1 high", {16'd0, q}, {16'd0, mem[9][31:16]});
    wait_idle();
    xfer(2'b01, 1'b1, 1'b0, 16'h0, q, sb);
    check("R8 addr advanced", {16'd0, q}, 32'h0028);

    // R9 fixed mode
    c0 = req_cnt;
    for (int k = 0; k < 2; k++) begin
      xfer(2'b11, 1'b1, 1'b0, 16'h0, q, sb);
      xfer(2'b11, 1'b1, 1'b1, 16'h0, q, sb);
      check("R9 data", {16'd0, q}, {16'd0, mem[10][31:16]});
    end
    wait_idle();
    check("R9 two fetches", req_cnt, c0 + 2);
    xfer(2'b01, 1'b1, 1'b0, 16'h0, q, sb);
    check("R9 addr fixed", {16'd0, q}, 32'h0028);

    // R10 strobe during busy ignored
    xfer(2'b11, 1'b0, 1'b0, 16'h0001, q, sb);
    host_sel = 2'b11; host_rnw = 1'b0; host_half = 1'b1; host_din = 16'h0002; host_stb = 1'b1;
    @(negedge clk);
    check("R6 busy seen", {31'd0, host_busy}, 32'd1);
    host_stb = 1'b0;
    @(negedge clk);
    host_sel = 2'b00; host_half = 1'b0; host_din = 16'h0000; host_stb = 1'b1;
    @(negedge clk);
    host_stb = 1'b0;
    wait_idle();
    xfer(2'b00, 1'b1, 1'b0, 16'h0, q, sb);
    check("R10 ctrl unchanged", {16'd0, q}, 32'h0001);

    // R11 output enable
    host_sel = 2'b11; host_rnw = 1'b1; host_half = 1'b0; host_stb = 1'b0;
    @(negedge clk);
    check("R11 doe idle", {31'd0, host_doe}, 32'd0);
    host_stb = 1'b1;
    @(negedge clk);
    check("R11 doe while busy", {31'd0, host_doe}, 32'd0);
    while (host_busy) @(negedge clk);
    check("R11 doe ready", {31'd0, host_doe}, 32'd1);
    host_stb = 1'b0;
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule